// File: doc/BRIEF.md
# Buffered Host-to-Serial-Link Bridge

This block connects an 8-bit host I/O port bus to a byte-wide serial-link adapter. The adapter shows when it holds a received byte and when it can take a byte to send. Each direction has its own deep FIFO. The host can therefore stream bytes with back-to-back string transfers and skip the adapter handshake for each byte. A transfer engine moves bytes between the FIFOs and the adapter on its own, while the host is busy elsewhere on the bus.

The bridge answers in two 8-byte I/O windows:

- The buffered (fast) window goes through the FIFOs.
- The plain (slow) window talks to the adapter directly. There the host polls the adapter status before every byte.

A control bit exchanges the two windows. Both windows also show:

- the shared control register,
- the interrupt-enable register,
- the FIFO status register,
- a 4-bit card identifier read from static switches.

The bridge can stretch every host access by a programmed number of wait cycles. An interrupt line is raised from FIFO fill conditions that the host enables one by one.

Top module: `hostlink_bridge`

## Requirements
- R1: Each direction has its own FIFO of DEPTH (default 1024) bytes. Bytes leave each FIFO in the order they entered, and a FIFO never holds more than DEPTH bytes.
- R2: The FIFO status register at window offset 7 reads as follows: bit0 in-empty, bit1 in-half, bit2 in-full, bit3 out-empty, bit4 out-half, bit5 out-full, bit6 read-underrun error, bit7 write-overflow error.
- R3: A FIFO's half flag is set when its fill count is DEPTH/2 (512) or more, and clear below that.
- R4: The interrupt enable register is at offset 5 and holds five bits: bit0 in-half, bit1 out-full, bit2 in-not-empty, bit3 out-empty, bit4 any sticky error. irq is the OR of the enabled conditions, and the register resets to 0.
- R5: With control bit0 (swap) clear, the buffered window sits at I/O base 0x150 and the plain window at 0x158. With swap set, the two bases trade places.
- R6: In the plain window, the adapter is reached directly:
  - A write at offset 1 drives lnk_out_write for that access cycle with the host byte, whatever lnk_out_ready is.
  - A read at offset 0 returns lnk_in_data and pulses lnk_in_ack.
  - Offset 2 bit0 reads lnk_in_valid, and offset 3 bit0 reads lnk_out_ready.
- R7: Offset 6 returns the card_id input in bits 3:0, with zeros above, in both windows.
- R8: Control bits 5:2 give the wait-state count N. io_ready rises in the (N+1)-th cycle of a held strobe, and the access takes effect in that cycle.
- R9: The engine hands a byte from the output FIFO to the adapter only in a cycle where lnk_out_ready is high, one byte per lnk_out_write cycle.
- R10: The engine stores an adapter byte into the input FIFO only when lnk_in_valid is high and the FIFO is not full, acknowledging with a one-cycle lnk_in_ack. While the FIFO is full, no acknowledge is given.
- R11: Two host errors are handled the same way:
  - A buffered-window write to a full output FIFO is dropped and sets sticky bit7.
  - A buffered-window data read of an empty input FIFO returns 0 and sets sticky bit6.

  Any write to the control register clears both error bits.
- R12: The following read as zero: addresses outside both windows, and offset 1 of either window. In the buffered window, offset 2 bit0 reads input-FIFO-not-empty and offset 3 bit0 reads output-FIFO-not-full.
- R13: Control bit1 (engine enable, reset 1) gates the transfer engine. While it is 0, no byte moves between the FIFOs and the adapter. The control register resets to 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 10 | Host I/O address |
| io_rd | input | 1 | Host read strobe, held until io_ready |
| io_wr | input | 1 | Host write strobe, held until io_ready |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid while io_ready |
| io_ready | output | 1 | Access completes in this cycle |
| irq | output | 1 | Host interrupt request |
| card_id | input | 4 | Static card identifier switches |
| lnk_in_data | input | 8 | Byte offered by the adapter |
| lnk_in_valid | input | 1 | Adapter holds a received byte |
| lnk_in_ack | output | 1 | One-cycle acknowledge of the received byte |
| lnk_out_data | output | 8 | Byte to the adapter |
| lnk_out_write | output | 1 | Strobe writing lnk_out_data to the adapter |
| lnk_out_ready | input | 1 | Adapter can accept a byte |

## Verification
The hardest states to reach from the ports are the fill-count boundaries: the input FIFO full while the adapter still offers bytes, and the half flag switching between 512 and 511 entries. The bench reaches them with an adapter model that offers a counted stream of 1030 bytes. The model stalls once the FIFO fills, and the bench then drains the FIFO one read at a time, sampling the status register on each side of the half mark. Overflow is reached the same way: the adapter's ready is held low while 1025 bytes are written. Ready is then released, and the bench checks that exactly the first 1024 bytes come out in order.

// File: rtl/hlb_pkg.sv
package hlb_pkg;

  // register offsets inside an 8-byte window
  localparam logic [2:0] OFS_DIN   = 3'd0;
  localparam logic [2:0] OFS_DOUT  = 3'd1;
  localparam logic [2:0] OFS_ISTAT = 3'd2;
  localparam logic [2:0] OFS_OSTAT = 3'd3;
  localparam logic [2:0] OFS_CTRL  = 3'd4;
  localparam logic [2:0] OFS_IEN   = 3'd5;
  localparam logic [2:0] OFS_ID    = 3'd6;
  localparam logic [2:0] OFS_FSTAT = 3'd7;

  typedef struct packed {
    logic full;
    logic half;
    logic empty;
  } fill_t;

  // half mark: fill count of at least half the depth
  function automatic logic at_half(input logic [31:0] cnt, input logic [31:0] depth);
    return cnt >= (depth >> 1);
  endfunction

  function automatic logic at_full(input logic [31:0] cnt, input logic [31:0] depth);
    return cnt == depth;
  endfunction

endpackage

// File: rtl/hlb_fifo.sv
module hlb_fifo
  import hlb_pkg::*;
#(
  parameter int DEPTH = 1024,   // power of two
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output fill_t         flags
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign flags.empty = (cnt == '0);
  assign flags.full  = at_full(32'(cnt), 32'(DEPTH));
  assign flags.half  = at_half(32'(cnt), 32'(DEPTH));

  assign do_push = push && !flags.full;
  assign do_pop  = pop && !flags.empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R1
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.full && push && !pop) |=> flags.full); // R11
  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.empty && pop && !push) |=> flags.empty); // R11
  AST_FULL_IS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    flags.full |-> flags.half); // R3

endmodule

// File: rtl/hlb_engine.sv
module hlb_engine (
  input  logic enable,
  input  logic out_empty,
  input  logic lnk_out_ready,
  input  logic slow_out_wr,
  input  logic in_full,
  input  logic lnk_in_valid,
  input  logic slow_in_ack,
  output logic out_pop,
  output logic in_push
);
  // plain-window traffic owns the adapter in the cycle it happens
  assign out_pop = enable && !out_empty && lnk_out_ready && !slow_out_wr;
  assign in_push = enable && lnk_in_valid && !in_full && !slow_in_ack;
endmodule

// File: rtl/hostlink_bridge.sv
module hostlink_bridge
  import hlb_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int FAST_BASE = 'h150,
  parameter int SLOW_BASE = 'h158,
  parameter int DEPTH     = 1024,
  parameter int WS_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_ready,
  output logic              irq,
  input  logic [3:0]        card_id,
  input  logic [7:0]        lnk_in_data,
  input  logic              lnk_in_valid,
  output logic              lnk_in_ack,
  output logic [7:0]        lnk_out_data,
  output logic              lnk_out_write,
  input  logic              lnk_out_ready
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(FAST_BASE);
  localparam logic [ADDR_W-1:0] BASE_B = ADDR_W'(SLOW_BASE);

  // control state
  logic            swap, eng_en;
  logic [WS_W-1:0] ws, ws_cnt;
  logic [4:0]      ien;
  logic            err_ovf, err_unf;

  // decode
  logic       win_a, win_b, fast_hit, slow_hit, any_hit, access, rd_go, wr_go;
  logic [2:0] ofs;

  assign win_a    = io_addr[ADDR_W-1:3] == BASE_A[ADDR_W-1:3];
  assign win_b    = io_addr[ADDR_W-1:3] == BASE_B[ADDR_W-1:3];
  assign fast_hit = swap ? win_b : win_a;
  assign slow_hit = swap ? win_a : win_b;
  assign any_hit  = fast_hit || slow_hit;
  assign ofs      = io_addr[2:0];
  assign access   = io_rd || io_wr;
  assign io_ready = access && (ws_cnt == ws);
  assign rd_go    = io_ready && io_rd;
  assign wr_go    = io_ready && io_wr;

  // named access events
  logic host_push, host_pop, slow_out_wr, slow_in_ack, ctrl_wr, ien_wr;
  assign host_push   = wr_go && fast_hit && ofs == OFS_DOUT;
  assign host_pop    = rd_go && fast_hit && ofs == OFS_DIN;
  assign slow_out_wr = wr_go && slow_hit && ofs == OFS_DOUT;
  assign slow_in_ack = rd_go && slow_hit && ofs == OFS_DIN;
  assign ctrl_wr     = wr_go && any_hit && ofs == OFS_CTRL;
  assign ien_wr      = wr_go && any_hit && ofs == OFS_IEN;

  // FIFOs and engine
  fill_t      in_f, out_f;
  logic [7:0] in_head, out_head;
  logic       eng_pop, eng_push, ovf_evt, unf_evt;

  hlb_fifo #(.DEPTH(DEPTH), .DW(8)) u_out_fifo (
    .clk(clk), .rst_n(rst_n), .push(host_push), .wdata(io_wdata),
    .pop(eng_pop), .rdata(out_head), .flags(out_f)
  );

  hlb_fifo #(.DEPTH(DEPTH), .DW(8)) u_in_fifo (
    .clk(clk), .rst_n(rst_n), .push(eng_push), .wdata(lnk_in_data),
    .pop(host_pop), .rdata(in_head), .flags(in_f)
  );

  hlb_engine u_engine (
    .enable(eng_en), .out_empty(out_f.empty), .lnk_out_ready(lnk_out_ready),
    .slow_out_wr(slow_out_wr), .in_full(in_f.full), .lnk_in_valid(lnk_in_valid),
    .slow_in_ack(slow_in_ack), .out_pop(eng_pop), .in_push(eng_push)
  );

  assign ovf_evt = host_push && out_f.full;
  assign unf_evt = host_pop && in_f.empty;

  assign lnk_out_write = slow_out_wr || eng_pop;
  assign lnk_out_data  = slow_out_wr ? io_wdata : out_head;
  assign lnk_in_ack    = slow_in_ack || eng_push;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_cnt  <= '0;
      swap    <= 1'b0;
      eng_en  <= 1'b1;
      ws      <= '0;
      ien     <= '0;
      err_ovf <= 1'b0;
      err_unf <= 1'b0;
    end else begin
      ws_cnt <= (!access || io_ready) ? '0 : ws_cnt + WS_W'(1);
      if (ctrl_wr) begin
        swap    <= io_wdata[0];
        eng_en  <= io_wdata[1];
        ws      <= io_wdata[2 +: WS_W];
        err_ovf <= 1'b0;
        err_unf <= 1'b0;
      end else begin
        if (ovf_evt) err_ovf <= 1'b1;
        if (unf_evt) err_unf <= 1'b1;
      end
      if (ien_wr) ien <= io_wdata[4:0];
    end
  end

  // interrupt
  logic [4:0] irq_src;
  assign irq_src = {err_ovf || err_unf, out_f.empty, !in_f.empty, out_f.full, in_f.half};
  assign irq     = |(ien & irq_src);

  // read mux
  always_comb begin
    io_rdata = '0;
    if (io_rd && any_hit) begin
      case (ofs)
        OFS_DIN:   io_rdata = fast_hit ? (in_f.empty ? 8'h00 : in_head) : lnk_in_data;
        OFS_ISTAT: io_rdata = {7'b0, fast_hit ? !in_f.empty : lnk_in_valid};
        OFS_OSTAT: io_rdata = {7'b0, fast_hit ? !out_f.full : lnk_out_ready};
        OFS_CTRL:  io_rdata = 8'({ws, eng_en, swap});
        OFS_IEN:   io_rdata = {3'b0, ien};
        OFS_ID:    io_rdata = {4'b0, card_id};
        OFS_FSTAT: io_rdata = {err_ovf, err_unf, out_f.full, out_f.half, out_f.empty,
                               in_f.full, in_f.half, in_f.empty};
        default:   io_rdata = '0;
      endcase
    end
  end

  AST_WAIT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (io_ready && ws != '0) |-> $past(access)); // R8
  AST_ACK_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_in_ack && !slow_in_ack) |=> !in_f.empty); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovf && !ctrl_wr) |=> err_ovf); // R11
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != '0)); // R4
  AST_SEND_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_out_write && !slow_out_wr) |-> (lnk_out_ready && eng_en)); // R9

endmodule

// File: tb/tb_hostlink_bridge.sv
`timescale 1ns/1ps
module tb_hostlink_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] io_addr = '0;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic       io_ready, irq;
  logic [3:0] card_id = 4'hA;
  logic [7:0] lnk_in_data, lnk_out_data;
  logic       lnk_in_valid, lnk_in_ack, lnk_out_write, lnk_out_ready;

  // adapter model state
  int         in_idx, in_lim = 0, cap_n, gap, gap_set = 0;
  logic       in_en = 1'b0, out_en = 1'b0;
  logic [7:0] cap [2048];

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  assign lnk_in_valid  = in_en && (in_idx < in_lim);
  assign lnk_in_data   = 8'(in_idx) ^ 8'h3C;
  assign lnk_out_ready = out_en && (gap == 0);

  hostlink_bridge dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready), .irq(irq),
    .card_id(card_id), .lnk_in_data(lnk_in_data), .lnk_in_valid(lnk_in_valid),
    .lnk_in_ack(lnk_in_ack), .lnk_out_data(lnk_out_data),
    .lnk_out_write(lnk_out_write), .lnk_out_ready(lnk_out_ready)
  );

  // adapter model
  initial begin
    in_idx = 0; cap_n = 0; gap = 0;
    forever begin
      @(posedge clk);
      if (lnk_out_write) begin
        cap[cap_n] <= lnk_out_data;
        cap_n <= cap_n + 1;
        gap <= gap_set;
      end else if (gap > 0) begin
        gap <= gap - 1;
      end
      if (lnk_in_ack) in_idx <= in_idx + 1;
    end
  end

  typedef struct packed {
    logic [3:0] req;
    logic       wr;
    logic [9:0] addr;
    logic [7:0] data;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{4'd7,  1'b0, 10'h156, 8'h0A},  // R7 card id, fast window
    '{4'd7,  1'b0, 10'h15E, 8'h0A},  // R7 card id, slow window
    '{4'd13, 1'b0, 10'h154, 8'h02},  // R13 control reset value
    '{4'd2,  1'b0, 10'h157, 8'h09},  // R2 both FIFOs empty
    '{4'd4,  1'b0, 10'h155, 8'h00},  // R4 enable reset
    '{4'd12, 1'b0, 10'h151, 8'h00},  // R12 write-only offset
    '{4'd12, 1'b0, 10'h160, 8'h00},  // R12 outside windows
    '{4'd12, 1'b0, 10'h152, 8'h00},  // R12 input FIFO empty
    '{4'd12, 1'b0, 10'h153, 8'h01},  // R12 output FIFO not full
    '{4'd4,  1'b1, 10'h155, 8'h1F},  // R4 write enables
    '{4'd4,  1'b0, 10'h15D, 8'h1F},  // R4 read back via other window
    '{4'd6,  1'b0, 10'h15B, 8'h00},  // R6 slow out status follows ready
    '{4'd4,  1'b1, 10'h155, 8'h00}   // R4 clear enables
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [9:0] a, input logic [7:0] d,
                     output logic [7:0] q, output int waits);
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = !w; io_wdata = d; waits = 0;
    #1;
    while (!io_ready) begin
      @(negedge clk); #1; waits++;
    end
    q = io_rdata;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    logic [7:0] q; int w;
    bus(1'b1, a, d, q, w);
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] q);
    int w;
    bus(1'b0, a, 8'h00, q, w);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] q;
    int w, n0, base, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 irq at reset", 32'(irq), 32'h0);
    chk("R9 no write at reset", 32'(lnk_out_write), 32'h0);
    chk("R10 no ack at reset", 32'(lnk_in_ack), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        wr(VEC[i].addr, VEC[i].data);
      end else begin
        rd(VEC[i].addr, q);
        n_chk++;
        if (q !== VEC[i].data) begin
          n_fail++;
          $display("FAIL R%0d vector %0d actual=%0h expected=%0h", VEC[i].req, i, q, VEC[i].data);
        end
      end
    end

    // R4 interrupt from out-empty
    wr(10'h155, 8'h08);
    chk("R4 irq out-empty", 32'(irq), 32'h1);
    wr(10'h155, 8'h00);
    chk("R4 irq disabled", 32'(irq), 32'h0);

    // R6 plain window with engine off (R13)
    wr(10'h154, 8'h00);
    in_lim = in_idx + 1; in_en = 1'b1;
    rd(10'h15A, q);
    chk("R6 slow in status", 32'(q), 32'h1);
    rd(10'h158, q);
    chk("R6 slow read data", 32'(q), 32'(8'(0) ^ 8'h3C));
    chk("R6 slow read ack", 32'(lnk_in_valid), 32'h0);
    in_en = 1'b0;
    n0 = cap_n;
    wr(10'h159, 8'h5C);
    chk("R6 slow write ignores ready", 32'(cap_n), 32'(n0 + 1));
    chk("R6 slow write data", 32'(cap[n0]), 32'h5C);

    // R13 engine off holds bytes; R9 gap honoured; R1 order
    n0 = cap_n;
    wr(10'h151, 8'h11); wr(10'h151, 8'h22); wr(10'h151, 8'h33);
    out_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R13 engine off no send", 32'(cap_n), 32'(n0));
    rd(10'h157, q);
    chk("R13 out FIFO holds", 32'(q), 32'h01);
    gap_set = 3;
    wr(10'h154, 8'h02);
    repeat (30) @(negedge clk);
    chk("R9 count sent", 32'(cap_n), 32'(n0 + 3));
    chk("R1 order b0", 32'(cap[n0]), 32'h11);
    chk("R1 order b1", 32'(cap[n0 + 1]), 32'h22);
    chk("R9 order b2", 32'(cap[n0 + 2]), 32'h33);
    gap_set = 0;

    // R5 swap windows
    out_en = 1'b0;
    repeat (5) @(negedge clk);
    wr(10'h154, 8'h03);
    n0 = cap_n;
    wr(10'h159, 8'h77);
    repeat (3) @(negedge clk);
    chk("R5 swapped buffered window", 32'(cap_n), 32'(n0));
    wr(10'h151, 8'h66);
    chk("R5 swapped plain window", 32'(cap_n), 32'(n0 + 1));
    chk("R5 plain data", 32'(cap[n0]), 32'h66);
    out_en = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 buffered byte sent", 32'(cap[n0 + 1]), 32'h77);
    wr(10'h154, 8'h02);

    // R8 wait states
    wr(10'h154, 8'h0E);
    bus(1'b0, 10'h154, 8'h00, q, w);
    chk("R8 three waits", 32'(w), 32'd3);
    chk("R8 ctrl read", 32'(q), 32'h0E);
    wr(10'h154, 8'h02);
    bus(1'b0, 10'h156, 8'h00, q, w);
    chk("R8 zero waits", 32'(w), 32'd0);

    // R10 fill input FIFO
    out_en = 1'b0;
    base = in_idx;
    in_lim = in_idx + 1030; in_en = 1'b1;
    repeat (1100) @(negedge clk);
    chk("R10 stored count", 32'(in_idx - base), 32'd1024);
    chk("R10 valid held", 32'(lnk_in_valid), 32'h1);
    chk("R10 no ack when full", 32'(lnk_in_ack), 32'h0);
    rd(10'h157, q);
    chk("R2 in full status", 32'(q), 32'h0E);
    wr(10'h155, 8'h01);
    chk("R4 irq in-half", 32'(irq), 32'h1);
    in_en = 1'b0;
    bad = 0;
    for (int k = 0; k < 1024; k++) begin
      if (k == 512) begin
        rd(10'h157, q);
        chk("R3 half at 512", 32'(q), 32'h0A);
      end
      if (k == 513) begin
        rd(10'h157, q);
        chk("R3 not half at 511", 32'(q), 32'h08);
      end
      rd(10'h150, q);
      if (q !== (8'(base + k) ^ 8'h3C)) bad++;
    end
    chk("R1 input order", 32'(bad), 32'd0);
    rd(10'h150, q);
    chk("R11 empty read zero", 32'(q), 32'h00);
    rd(10'h157, q);
    chk("R11 underrun flag", 32'(q), 32'h49);
    wr(10'h154, 8'h02);
    rd(10'h157, q);
    chk("R11 cleared by ctrl write", 32'(q), 32'h09);
    wr(10'h155, 8'h00);

    // R11 overflow and R1 output depth
    n0 = cap_n;
    for (int k = 0; k < 1025; k++) wr(10'h151, 8'(k * 7));
    rd(10'h157, q);
    chk("R11 overflow flag", 32'(q), 32'hB1);
    wr(10'h155, 8'h02);
    chk("R4 irq out-full", 32'(irq), 32'h1);
    wr(10'h155, 8'h00);
    wr(10'h154, 8'h02);
    out_en = 1'b1;
    repeat (1100) @(negedge clk);
    chk("R11 extra byte dropped", 32'(cap_n), 32'(n0 + 1024));
    bad = 0;
    for (int k = 0; k < 1024; k++) if (cap[n0 + k] !== 8'(k * 7)) bad++;
    chk("R1 output order", 32'(bad), 32'd0);
    rd(10'h157, q);
    chk("R2 idle status", 32'(q), 32'h09);

    summary();
  end
endmodule